// File: doc/BRIEF.md
# Coprocessor Card Host Control and Status Register

This block gives a host a small byte-addressed register window through which it can manage a coprocessor card. The host can start and hold the card processor, enable the card's shared-memory address decode, and gate one combined host interrupt line. The card processor raises one interrupt flag per host channel. The host reads the flags and acknowledges each one by writing 1 to it. A flag that is set stays visible to the host whether or not interrupts are enabled.

A single run bit serves as both the processor's run command and its reset. Whenever the processor is not running, the status LED is forced red. A watchdog timeout halts the processor even while the run bit stays at 1. The timeout stays latched until the host drops the run bit. Every time the run bit falls, a cycle counter enforces a minimum reset low time. The counter length is derived from the core clock frequency and a minimum time in microseconds. If the host raises the run bit again too early, the processor is still held until the counter has confirmed that time.

The register window holds two 8-byte channel windows: channel A at byte addresses 0 to 7 and channel B at 8 to 15. Offset 0 of each window aliases one shared control byte. Offset 1 holds that channel's interrupt flag.

Top module: `card_host_csr`

## Requirements
- R1: After reset, all control bits are 0. The control byte at address 0 reads 0x00, both flags read 0, `cpuRun` is 0, `ledForceRed` is 1, and `memDecodeEn` and `hostIrq` are 0.
- R2: The control byte is reached at offset 0 of either channel window (addresses 0 and 8). Its bits are: bit 0 run, bit 1 memory-decode enable, bit 2 interrupt enable, bit 3 timeout status (read-only; writes to it are ignored). Bits 7..4 read 0. `memDecodeEn` follows bit 1.
- R3: `cpuRun` is 1 only when the run bit is 1, the minimum low time has elapsed and no watchdog timeout is latched. `ledForceRed` is the inverse of `cpuRun`.
- R4: Let the run bit be cleared at clock edge E0, or let reset be released. `cpuRun` then stays 0 through edge E0+MIN_LOW_CYC-1 and may be 1 only from edge E0+MIN_LOW_CYC onward, even if run is written back to 1 earlier. Writing run=0 while run is already 0 does not restart this count.
- R5: If `wdTimeout` is 1 at a clock edge while the run bit is 1, a timeout is latched. The processor is halted from that edge on, even if run is rewritten to 1. The latch is cleared by the edge that writes run=0. `wdTimeout` is ignored while run is 0.
- R6: The timeout status bit reads 1 whenever a timeout is latched. It also reads 1 whenever run is 1 but the minimum low time has not yet elapsed.
- R7: Bit 0 of offset 1 is the channel's interrupt flag: address 1 for channel A (`cardIrq[0]`) and address 9 for channel B (`cardIrq[1]`). A 1 on `cardIrq[i]` at an edge sets flag i. A host write with data bit 0 = 1 clears it, and a write with bit 0 = 0 has no effect. Bits 7..1 read 0.
- R8: If `cardIrq[i]` is 1 at the same edge as a host clear of flag i, the flag ends up set.
- R9: `hostIrq` is 1 exactly when interrupt enable is 1 and at least one flag is 1. With enable at 0, flags still set, clear and read back normally.
- R10: Offsets 2 to 7 of both windows read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe, one byte per cycle |
| hostAddr | input | 4 | Host byte address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data for `hostAddr` (combinational) |
| cpuRun | output | 1 | 1 = processor runs, 0 = processor held in reset |
| ledForceRed | output | 1 | 1 = status LED forced red, 0 = processor owns the LED |
| wdTimeout | input | 1 | Watchdog timeout indication from the card |
| memDecodeEn | output | 1 | Enables shared-memory address decode |
| cardIrq | input | 2 | Card interrupt requests; bit 0 channel A, bit 1 channel B |
| hostIrq | output | 1 | Combined host interrupt |

## Verification
The bench walks the processor release cycle by cycle after run is dropped and immediately re-raised. A design that released on the run bit alone, or counted only from the rewrite, would show `cpuRun` early and would clear the timeout status bit too soon. It also raises the watchdog and then rewrites run=1. A design that cleared the latch on any control write would resume the processor there. It lands a card set on the same edge as a host clear, which a clear-wins flag would lose. It sweeps the interrupt enable against every flag pattern and checks that pending flags stay readable while the line is gated.

// File: rtl/card_csr_pkg.sv
package card_csr_pkg;
  localparam int CH_NUM   = 2;
  localparam int CH_BYTES = 8;
  localparam int DATA_W   = 8;
  localparam int OFS_W    = $clog2(CH_BYTES);
  localparam int ADDR_W   = $clog2(CH_NUM * CH_BYTES);
  localparam int CH_SEL_W = ADDR_W - OFS_W;

  localparam logic [OFS_W-1:0] OFS_CTRL = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_FLAG = OFS_W'(1);

  // control byte layout
  localparam int BIT_RUN = 0;
  localparam int BIT_MEM = 1;
  localparam int BIT_IEN = 2;
  localparam int BIT_WDT = 3;

  typedef struct packed {
    logic              ctrlWr;   // control byte written
    logic              runDrop;  // run bit goes 1 -> 0 on this write
    logic [CH_NUM-1:0] flagClr;  // write-1 acknowledge per channel
  } csrStrobe_t;
endpackage

// File: rtl/card_csr_decode.sv
module card_csr_decode
  import card_csr_pkg::*;
(
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              runBit,
  output csrStrobe_t        strobe
);
  logic [OFS_W-1:0]    ofs;
  logic [CH_SEL_W-1:0] chSel;
  logic                unusedWdata;

  assign ofs         = hostAddr[OFS_W-1:0];
  assign chSel       = hostAddr[ADDR_W-1:OFS_W];
  assign unusedWdata = ^hostWdata[DATA_W-1:BIT_IEN+1];

  always_comb begin
    strobe.ctrlWr  = hostWr && (ofs == OFS_CTRL);
    strobe.runDrop = hostWr && (ofs == OFS_CTRL) && runBit && !hostWdata[BIT_RUN];
    for (int ch = 0; ch < CH_NUM; ch++) begin
      strobe.flagClr[ch] = hostWr && (ofs == OFS_FLAG) &&
                           (chSel == CH_SEL_W'(ch)) && hostWdata[0];
    end
  end
endmodule

// File: rtl/card_csr_rst_timer.sv
module card_csr_rst_timer #(
  parameter int unsigned MIN_LOW_CYC = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic lowDone
);
  localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_CYC);

  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (restart) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign lowDone = (lowCnt == CNT_MAX);
endmodule

// File: rtl/card_csr_regs.sv
module card_csr_regs
  import card_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [BIT_IEN:0]  ctrlIn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wdTimeout,
  input  logic [CH_NUM-1:0] cardIrq,
  input  logic              lowDone,
  output logic              runBit,
  output logic              memEn,
  output logic              irqEn,
  output logic [CH_NUM-1:0] flags,
  output logic              cpuRun,
  output logic              hostIrq,
  output logic [DATA_W-1:0] rdData
);
  logic                wdLatched;
  logic                timeoutFlag;
  logic [OFS_W-1:0]    ofs;
  logic [CH_SEL_W-1:0] chSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit <= 1'b0;
      memEn  <= 1'b0;
      irqEn  <= 1'b0;
    end else if (strobe.ctrlWr) begin
      runBit <= ctrlIn[BIT_RUN];
      memEn  <= ctrlIn[BIT_MEM];
      irqEn  <= ctrlIn[BIT_IEN];
    end
  end

  // sticky timeout, released only by dropping run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdLatched <= 1'b0;
    end else if (!runBit || strobe.runDrop) begin
      wdLatched <= 1'b0;
    end else if (wdTimeout) begin
      wdLatched <= 1'b1;
    end
  end

  // per-channel flags: card set beats host clear
  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[ch] <= 1'b0;
      end else begin
        flags[ch] <= cardIrq[ch] | (flags[ch] & ~strobe.flagClr[ch]);
      end
    end
  end

  assign cpuRun      = runBit & lowDone & ~wdLatched;
  assign timeoutFlag = wdLatched | (runBit & ~lowDone);
  assign hostIrq     = irqEn & (|flags);

  assign ofs   = rdAddr[OFS_W-1:0];
  assign chSel = rdAddr[ADDR_W-1:OFS_W];

  always_comb begin
    rdData = '0;
    case (ofs)
      OFS_CTRL: begin
        rdData[BIT_RUN] = runBit;
        rdData[BIT_MEM] = memEn;
        rdData[BIT_IEN] = irqEn;
        rdData[BIT_WDT] = timeoutFlag;
      end
      OFS_FLAG: rdData[0] = flags[chSel];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/card_host_csr.sv
module card_host_csr
  import card_csr_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned MIN_LOW_US = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              cpuRun,
  output logic              ledForceRed,
  input  logic              wdTimeout,
  output logic              memDecodeEn,
  input  logic [CH_NUM-1:0] cardIrq,
  output logic              hostIrq
);
  localparam int unsigned MIN_LOW_RAW = (CLK_KHZ * MIN_LOW_US + 999) / 1000;
  localparam int unsigned MIN_LOW_CYC = (MIN_LOW_RAW < 1) ? 1 : MIN_LOW_RAW;

  csrStrobe_t        strobe;
  logic              runBit;
  logic              memEn;
  logic              irqEn;
  logic              lowDone;
  logic [CH_NUM-1:0] flags;

  card_csr_decode u_decode (
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .runBit    (runBit),
    .strobe    (strobe)
  );

  card_csr_rst_timer #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strobe.runDrop),
    .lowDone (lowDone)
  );

  card_csr_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ctrlIn    (hostWdata[BIT_IEN:0]),
    .rdAddr    (hostAddr),
    .wdTimeout (wdTimeout),
    .cardIrq   (cardIrq),
    .lowDone   (lowDone),
    .runBit    (runBit),
    .memEn     (memEn),
    .irqEn     (irqEn),
    .flags     (flags),
    .cpuRun    (cpuRun),
    .hostIrq   (hostIrq),
    .rdData    (hostRdata)
  );

  assign ledForceRed = ~cpuRun;
  assign memDecodeEn = memEn;
endmodule

// File: rtl/card_host_csr_chk.sv
module card_host_csr_chk #(
  parameter int unsigned MIN_LOW_CYC = 5000
) (
  input logic       clk,
  input logic       rstN,
  input logic       runBit,
  input logic       irqEn,
  input logic [1:0] flags,
  input logic       cpuRun,
  input logic       ledForceRed,
  input logic       wdTimeout,
  input logic [1:0] cardIrq,
  input logic       hostIrq
);
  // independent count of edges since run was last seen falling
  logic        prevRun;
  int unsigned sinceLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRun  <= 1'b0;
      sinceLow <= 0;
    end else begin
      prevRun <= runBit;
      if (prevRun && !runBit) sinceLow <= 1;
      else if (sinceLow < MIN_LOW_CYC) sinceLow <= sinceLow + 1;
    end
  end

  assert_halt_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> (!cpuRun && ledForceRed));

  assert_min_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |-> (sinceLow >= MIN_LOW_CYC));

  assert_wd_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && wdTimeout) |=> !cpuRun);

  assert_set_wins_a_R8: assert property (@(posedge clk) disable iff (!rstN)
    cardIrq[0] |=> flags[0]);

  assert_set_wins_b_R8: assert property (@(posedge clk) disable iff (!rstN)
    cardIrq[1] |=> flags[1]);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !hostIrq);
endmodule

bind card_host_csr card_host_csr_chk #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .runBit      (runBit),
  .irqEn       (irqEn),
  .flags       (flags),
  .cpuRun      (cpuRun),
  .ledForceRed (ledForceRed),
  .wdTimeout   (wdTimeout),
  .cardIrq     (cardIrq),
  .hostIrq     (hostIrq)
);

// File: tb/sim_card_host_csr.sv
module sim_card_host_csr;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned T_KHZ = 2000;
  localparam int unsigned T_US  = 4;
  localparam int MIN_LOW = (T_KHZ * T_US + 999) / 1000;  // 8 cycles

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       cpuRun;
  logic       ledForceRed;
  logic       wdTimeout = 1'b0;
  logic       memDecodeEn;
  logic [1:0] cardIrq = '0;
  logic       hostIrq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  card_host_csr #(.CLK_KHZ(T_KHZ), .MIN_LOW_US(T_US)) u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .cpuRun(cpuRun),
    .ledForceRed(ledForceRed), .wdTimeout(wdTimeout),
    .memDecodeEn(memDecodeEn), .cardIrq(cardIrq), .hostIrq(hostIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller stands just after a falling edge; write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v);  chk("R1 ctrl", v, 8'h00);
    rd(4'd1, v);  chk("R1 flagA", v, 8'h00);
    rd(4'd9, v);  chk("R1 flagB", v, 8'h00);
    chk("R1 cpuRun", {7'b0, cpuRun}, 8'h00);
    chk("R1 led", {7'b0, ledForceRed}, 8'h01);
    chk("R1 memDecodeEn", {7'b0, memDecodeEn}, 8'h00);
    chk("R1 hostIrq", {7'b0, hostIrq}, 8'h00);
    @(negedge clk);

    // R2 sweep of control byte with run held 0, through both aliases
    for (int d = 0; d < 256; d += 2) begin
      wr((d[1] ? 4'd8 : 4'd0), 8'(d));
      rd(4'd0, v);
      rd(4'd8, v2);
      chk("R2 ctrl addr0", v, {5'b0, 8'(d) >> 1 & 8'h03, 1'b0} );
      chk("R2 ctrl addr8", v2, {5'b0, 8'(d) >> 1 & 8'h03, 1'b0});
      chk("R2 memDecodeEn", {7'b0, memDecodeEn}, {7'b0, d[1]});
      @(negedge clk);
    end
    wr(4'd0, 8'h00);
    repeat (MIN_LOW + 2) @(negedge clk);

    // R3 run after long low: immediate release
    wr(4'd0, 8'h01);
    chk("R3 cpuRun", {7'b0, cpuRun}, 8'h01);
    chk("R3 led", {7'b0, ledForceRed}, 8'h00);
    rd(4'd0, v); chk("R6 no hold", v, 8'h01);
    @(negedge clk);

    // R4 / R6: drop run then re-raise at once
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h01);
    for (int k = 1; k <= MIN_LOW + 3; k++) begin
      chk($sformatf("R4 hold k=%0d", k), {7'b0, cpuRun}, {7'b0, (k >= MIN_LOW)});
      chk($sformatf("R3 led k=%0d", k), {7'b0, ledForceRed}, {7'b0, (k < MIN_LOW)});
      rd(4'd0, v);
      chk($sformatf("R6 tbit k=%0d", k), {7'b0, v[3]}, {7'b0, (k < MIN_LOW)});
      @(negedge clk);
    end

    // R4 rewriting 0 while already 0 does not restart
    wr(4'd0, 8'h00);
    repeat (MIN_LOW + 2) @(negedge clk);
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h01);
    chk("R4 no restart", {7'b0, cpuRun}, 8'h01);

    // R5 watchdog halts and stays latched
    wdTimeout = 1'b1;
    @(negedge clk);
    wdTimeout = 1'b0;
    chk("R5 halted", {7'b0, cpuRun}, 8'h00);
    chk("R5 led", {7'b0, ledForceRed}, 8'h01);
    rd(4'd0, v); chk("R5 tbit", v, 8'h09);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R5 still halted", {7'b0, cpuRun}, 8'h00);
    wr(4'd0, 8'h01);
    chk("R5 run rewrite keeps halt", {7'b0, cpuRun}, 8'h00);
    rd(4'd0, v); chk("R5 tbit after rewrite", v, 8'h09);
    @(negedge clk);
    wr(4'd0, 8'h00);
    rd(4'd0, v); chk("R5 cleared by run drop", v, 8'h00);
    @(negedge clk);
    wdTimeout = 1'b1;
    @(negedge clk);
    wdTimeout = 1'b0;
    repeat (MIN_LOW) @(negedge clk);
    wr(4'd0, 8'h01);
    chk("R5 ignored while low", {7'b0, cpuRun}, 8'h01);
    rd(4'd0, v); chk("R5 ignored tbit", v, 8'h01);
    @(negedge clk);
    wr(4'd0, 8'h00);

    // R7 / R9 sweep of enable against flag patterns
    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 4; p++) begin
        wr(4'd0, 8'(en << 2));
        wr(4'd1, 8'h01);
        wr(4'd9, 8'h01);
        cardIrq = 2'(p);
        @(negedge clk);
        cardIrq = 2'b00;
        rd(4'd1, v);  chk("R7 flagA set", v, {7'b0, p[0]});
        rd(4'd9, v);  chk("R7 flagB set", v, {7'b0, p[1]});
        chk("R9 hostIrq", {7'b0, hostIrq}, {7'b0, (en == 1) && (p != 0)});
        @(negedge clk);
        wr(4'd1, 8'hFE);
        wr(4'd9, 8'hFE);
        rd(4'd1, v);  chk("R7 write0 A", v, {7'b0, p[0]});
        rd(4'd9, v);  chk("R7 write0 B", v, {7'b0, p[1]});
        @(negedge clk);
        wr(4'd1, 8'h01);
        rd(4'd1, v);  chk("R7 clear A", v, 8'h00);
        rd(4'd9, v);  chk("R7 B kept", v, {7'b0, p[1]});
        chk("R9 hostIrq after clear", {7'b0, hostIrq}, {7'b0, (en == 1) && p[1]});
        @(negedge clk);
      end
    end

    // R8 same-edge set and clear
    wr(4'd1, 8'h01);
    wr(4'd9, 8'h01);
    cardIrq = 2'b01;
    wr(4'd1, 8'h01);
    cardIrq = 2'b00;
    rd(4'd1, v); chk("R8 set wins A", v, 8'h01);
    @(negedge clk);
    cardIrq = 2'b10;
    wr(4'd9, 8'h01);
    cardIrq = 2'b00;
    rd(4'd9, v); chk("R8 set wins B", v, 8'h01);
    @(negedge clk);
    wr(4'd1, 8'h01);

    // R10 unmapped offsets
    wr(4'd0, 8'h06);
    for (int a = 0; a < 16; a++) begin
      if (a[2:0] > 3'd1) begin
        wr(4'(a), 8'hFF);
        rd(4'(a), v);
        chk($sformatf("R10 addr %0d", a), v, 8'h00);
        @(negedge clk);
      end
    end
    rd(4'd0, v); chk("R10 ctrl kept", v, 8'h06);
    rd(4'd1, v); chk("R10 flagA kept", v, 8'h00);
    rd(4'd9, v); chk("R10 flagB kept", v, 8'h01);
    chk("R10 cpuRun kept", {7'b0, cpuRun}, 8'h00);
    @(negedge clk);

    finishRun();
  end
endmodule